// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the register-mapped command front end of an on-chip flash array. Software reaches it through a simple 32-bit register port with single-cycle writes and combinational reads. It holds the target address, the write-data words, a clock divider and a control word. From the control word it qualifies and launches a word write, a page erase or a full-array erase on a start/busy/done handshake toward the flash macro. The same divider turns the system clock into a one-microsecond timing strobe for the flash timing logic.

A command is launched only when three things hold: the control word carries the open lock value, an erase carries its matching key, and nothing is already in flight. A request that fails any of these never reaches the flash port. It sets an access-fail flag instead. Completion sets a done flag. Each flag has an enable, and the interrupt line is their masked OR.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the divider reads 0x7D (parameter default), the control and interrupt registers read 0, and `irq` and `fop_start` are low.
- R2: The target address reads and writes at offset 0x00, the divider (8 bits, upper bits read 0) at 0x04, and the data words at 0x30, 0x34, 0x38 and 0x3C, packed into `fop_data` with word 0 in the low bits. Any unmapped offset reads 0.
- R3: `tick_1us` is high for one cycle in every N cycles, where N is the divider value, and a divider value of 0 behaves as 1.
- R4: The control register holds start bits [2:0] (bit 0 write, bit 1 full erase, bit 2 page erase), the erase key in [15:8], the read-only in-flight bit in [24] and the lock field in [31:28]. An accepted start raises `fop_start` for exactly the cycle after the write and sets the in-flight bit and the start bit. `fop_code` is 1 for write, 2 for page erase and 3 for full erase.
- R5: A page erase needs erase key 0x55 and a full erase needs 0xAA. Otherwise the request is rejected.
- R6: A request whose lock field is not 0x2 is rejected. The lock and key fields of a control write made while idle are stored, even when the write is rejected.
- R7: A request with more than one start bit set is rejected.
- R8: A request made while an operation is in flight, or while `fop_busy` is high, is rejected. A control write made while in flight changes no control field.
- R9: `fop_done` while in flight clears the start bits and the in-flight bit and sets the done flag (interrupt bit 0).
- R10: Writes to the divider, the address and the data words are ignored while an operation is in flight.
- R11: The interrupt register holds the done flag in bit 0, the access-fail flag in bit 1 and their enables in bits 8 and 9. A rejection sets bit 1. Writing 0 to a flag clears it, and writing 1 leaves it unchanged. A set event in the same cycle as a clearing write leaves the flag set.
- R12: `irq` is high exactly when some flag is set together with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, 0 when not reading) |
| tick_1us | output | 1 | Divided timing strobe |
| fop_start | output | 1 | One-cycle launch pulse to the flash macro |
| fop_code | output | 2 | Operation code while in flight |
| fop_addr | output | 32 | Target address |
| fop_data | output | 128 | Write data words |
| fop_busy | input | 1 | Flash macro cannot accept a launch |
| fop_done | input | 1 | Flash macro finished the operation |
| irq | output | 1 | Masked interrupt request |

## Verification
The in-flight bit is the single piece of state that gates everything else. If it sticks high, the very next start request reads back as an access failure and divider writes stop taking effect, both visible within two cycles. If it drops early, a second `fop_start` can appear while the first operation still runs. A wrong qualification decision shows one cycle after the control write, either as a missing or extra `fop_start` or as a wrong access-fail bit on the next interrupt-register read. Divider faults show as a wrong tick count within a few tick periods.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [1:0] {
    FOP_NONE  = 2'd0,
    FOP_WRITE = 2'd1,
    FOP_PAGE  = 2'd2,
    FOP_MASS  = 2'd3
  } fop_e;

  localparam logic [7:0] OFS_ADDR = 8'h00;
  localparam logic [7:0] OFS_DIV  = 8'h04;
  localparam logic [7:0] OFS_CTL  = 8'h08;
  localparam logic [7:0] OFS_IRQ  = 8'h24;
  localparam logic [7:0] OFS_DATA = 8'h30;

  localparam logic [7:0] KEY_PAGE  = 8'h55;
  localparam logic [7:0] KEY_MASS  = 8'hAA;
  localparam logic [3:0] LOCK_OPEN = 4'h2;

  // start bits: [0] write, [1] full erase, [2] page erase
  function automatic fop_e go_to_op(input logic [2:0] go);
    if (go[0])      return FOP_WRITE;
    else if (go[2]) return FOP_PAGE;
    else if (go[1]) return FOP_MASS;
    else            return FOP_NONE;
  endfunction

  function automatic logic cmd_ok(input logic [2:0] go, input logic [3:0] lock,
                                  input logic [7:0] key);
    logic single;
    single = (go != 3'b000) && ((go & (go - 3'b001)) == 3'b000);
    return single && (lock == LOCK_OPEN) &&
           (go[0] || (go[1] && key == KEY_MASS) || (go[2] && key == KEY_PAGE));
  endfunction

endpackage

// File: rtl/fcc_tick_div.sv
module fcc_tick_div #(
  parameter int               DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 8'd125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_val,
  input  logic             hold,
  output logic [DIV_W-1:0] div_q,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  function automatic logic [DIV_W-1:0] last_count(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  wire div_load = wr_en && !hold;
  assign tick = (cnt_q == last_count(div_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_RST;
      cnt_q <= '0;
    end else if (div_load) begin
      div_q <= wr_val;
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: counter never passes the period end
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_count(div_q));

  // R10: divider frozen while an operation is in flight
  a_r10_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(div_q));

endmodule

// File: rtl/fcc_cmd_seq.sv
module fcc_cmd_seq
  import fcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [2:0] wr_go,
  input  logic [7:0] wr_key,
  input  logic [3:0] wr_lock,
  input  logic       fop_busy,
  input  logic       fop_done,
  output logic [2:0] go_q,
  output logic [7:0] key_q,
  output logic [3:0] lock_q,
  output logic       pend_q,
  output logic       fop_start,
  output fop_e       fop_code,
  output logic       cmd_accept,
  output logic       cmd_reject,
  output logic       cmd_finish
);

  wire req = ctl_wr && (wr_go != 3'b000);
  assign cmd_accept = req && !pend_q && !fop_busy && cmd_ok(wr_go, wr_lock, wr_key);
  assign cmd_reject = req && !cmd_accept;
  assign cmd_finish = pend_q && fop_done;
  assign fop_code   = go_to_op(go_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q      <= '0;
      key_q     <= '0;
      lock_q    <= '0;
      pend_q    <= 1'b0;
      fop_start <= 1'b0;
    end else begin
      fop_start <= cmd_accept;
      if (cmd_finish) begin
        go_q   <= '0;
        pend_q <= 1'b0;
      end else if (ctl_wr && !pend_q) begin
        lock_q <= wr_lock;
        key_q  <= wr_key;
        if (cmd_accept) begin
          go_q   <= wr_go;
          pend_q <= 1'b1;
        end
      end
    end
  end

  // R4: a launch pulse coincides with the rise of the in-flight bit
  a_r4_start_with_pend: assert property (@(posedge clk) disable iff (!rst_n)
    fop_start |-> $rose(pend_q));

  // R4: exactly one start bit is held while in flight
  a_r4_single_go: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> $onehot(go_q));

  // R8: no launch was decided while the macro reported busy
  a_r8_no_busy_launch: assert property (@(posedge clk) disable iff (!rst_n)
    fop_start |-> !$past(fop_busy));

  // R9: in-flight ends only on the done handshake
  a_r9_end_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(fop_done));

endmodule

// File: rtl/fcc_irq.sv
module fcc_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_wr,
  input  logic [1:0] wr_flags,
  input  logic [1:0] wr_en,
  input  logic       set_done,
  input  logic       set_fail,
  output logic [1:0] flags_q,
  output logic [1:0] en_q,
  output logic       irq
);

  logic [1:0] kept;
  assign kept = irq_wr ? (flags_q & wr_flags) : flags_q;
  assign irq  = |(flags_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= kept | {set_fail, set_done};
      if (irq_wr) en_q <= wr_en;
    end
  end

  // R11: the fail flag rises only from a rejection
  a_r11_fail_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[1]) |-> $past(set_fail));

  // R11: the done flag clears only by a zero written to it
  a_r11_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_q[0]) |-> $past(irq_wr && !wr_flags[0]));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int         WORDS   = 4,
  parameter int         ADDR_W  = 32,
  parameter int         DIV_W   = 8,
  parameter logic [7:0] DIV_RST = 8'd125
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                tick_1us,
  output logic                fop_start,
  output logic [1:0]          fop_code,
  output logic [ADDR_W-1:0]   fop_addr,
  output logic [32*WORDS-1:0] fop_data,
  input  logic                fop_busy,
  input  logic                fop_done,
  output logic                irq
);

  localparam int DATA_W = 32 * WORDS;

  wire wr = bus_sel && bus_we;
  wire rd = bus_sel && !bus_we;

  logic [2:0]       go_q;
  logic [7:0]       key_q;
  logic [3:0]       lock_q;
  logic             pend_q;
  logic             cmd_accept, cmd_reject, cmd_finish;
  fop_e             code_e;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       flags_q, en_q;
  logic [31:0]      data_q [WORDS];
  logic [ADDR_W-1:0] addr_q;

  fcc_tick_div #(.DIV_W(DIV_W), .DIV_RST(DIV_RST[DIV_W-1:0])) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr && bus_addr == OFS_DIV),
    .wr_val (bus_wdata[DIV_W-1:0]),
    .hold   (pend_q),
    .div_q  (div_q),
    .tick   (tick_1us)
  );

  fcc_cmd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (wr && bus_addr == OFS_CTL),
    .wr_go      (bus_wdata[2:0]),
    .wr_key     (bus_wdata[15:8]),
    .wr_lock    (bus_wdata[31:28]),
    .fop_busy   (fop_busy),
    .fop_done   (fop_done),
    .go_q       (go_q),
    .key_q      (key_q),
    .lock_q     (lock_q),
    .pend_q     (pend_q),
    .fop_start  (fop_start),
    .fop_code   (code_e),
    .cmd_accept (cmd_accept),
    .cmd_reject (cmd_reject),
    .cmd_finish (cmd_finish)
  );
  assign fop_code = code_e;

  fcc_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_wr   (wr && bus_addr == OFS_IRQ),
    .wr_flags (bus_wdata[1:0]),
    .wr_en    (bus_wdata[9:8]),
    .set_done (cmd_finish),
    .set_fail (cmd_reject),
    .flags_q  (flags_q),
    .en_q     (en_q),
    .irq      (irq)
  );

  // target address, frozen while in flight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       addr_q <= '0;
    else if (wr && !pend_q && bus_addr == OFS_ADDR)   addr_q <= bus_wdata[ADDR_W-1:0];
  end
  assign fop_addr = addr_q;

  // data words, one register per word
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [7:0] OFS_W = OFS_DATA + 8'(4 * w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  data_q[w] <= '0;
      else if (wr && !pend_q && bus_addr == OFS_W) data_q[w] <= bus_wdata;
    end
    assign fop_data[32*w +: 32] = data_q[w];
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (bus_addr)
        OFS_ADDR: bus_rdata = 32'(addr_q);
        OFS_DIV:  bus_rdata = 32'(div_q);
        OFS_CTL:  bus_rdata = {lock_q, 3'b000, pend_q, 8'h00, key_q, 5'b00000, go_q};
        OFS_IRQ:  bus_rdata = {22'd0, en_q, 6'd0, flags_q};
        default: begin
          for (int w = 0; w < WORDS; w++)
            if (bus_addr == OFS_DATA + 8'(4 * w)) bus_rdata = data_q[w];
        end
      endcase
    end
  end

  // R10: address and data are stable during an operation
  a_r10_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> $stable(fop_addr) && $stable(fop_data));

  // R8: a rejected request never launches
  a_r8_reject_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> !fop_start);

  localparam int UNUSED_W = DATA_W;

endmodule

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         tick_1us, fop_start, irq;
  logic [1:0]   fop_code;
  logic [31:0]  fop_addr;
  logic [127:0] fop_data;
  logic         fop_busy = 1'b0, fop_done = 1'b0;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_1us(tick_1us), .fop_start(fop_start), .fop_code(fop_code),
    .fop_addr(fop_addr), .fop_data(fop_data), .fop_busy(fop_busy),
    .fop_done(fop_done), .irq(irq)
  );

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t exp_q[$];
  logic     rd_arm = 1'b0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads and compares against the bus
  always @(negedge clk) begin
    if (rd_arm && exp_q.size() > 0) begin
      rd_item_t it;
      it = exp_q.pop_front();
      chk($sformatf("%s @%0h", it.tag, it.addr), 128'(bus_rdata), 128'(it.exp));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    rd_arm = 1'b1;
    @(posedge clk); #1;
    bus_sel = 1'b0; rd_arm = 1'b0;
  endtask

  task automatic finish_op();
    @(posedge clk); #1; fop_done = 1'b1;
    @(posedge clk); #1; fop_done = 0;
  endtask

  // write a control word and check the launch pulse that should or should not follow
  task automatic launch(input logic [31:0] d, input logic exp_go, input logic [1:0] exp_code,
                        input string tag);
    wr(8'h08, d);
    @(negedge clk);
    chk({tag, " start pulse"}, 128'(fop_start), 128'(exp_go));
    if (exp_go) chk({tag, " code"}, 128'(fop_code), 128'(exp_code));
    @(negedge clk);
    chk({tag, " pulse width"}, 128'(fop_start), 128'(0));
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick_1us) c++;
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 irq", 128'(irq), 128'(0));
    chk("R1 start", 128'(fop_start), 128'(0));
    rd(8'h04, 32'h7D, "R1 divider");
    rd(8'h08, 32'h0, "R1 control");
    rd(8'h24, 32'h0, "R1 interrupt");

    // R2 register map
    wr(8'h00, 32'h0000_1230);
    rd(8'h00, 32'h0000_1230, "R2 address");
    for (int w = 0; w < 4; w++) wr(8'h30 + 8'(4 * w), 32'hA000_0000 + 32'(w));
    for (int w = 0; w < 4; w++) rd(8'h30 + 8'(4 * w), 32'hA000_0000 + 32'(w), "R2 data");
    @(negedge clk);
    chk("R2 fop_data", fop_data,
        {32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000});
    chk("R2 fop_addr", 128'(fop_addr), 128'(32'h1230));
    rd(8'h0C, 32'h0, "R2 unmapped");
    wr(8'h04, 32'hFFFF_FF04);
    rd(8'h04, 32'h04, "R2 divider width");

    // R3 tick period
    count_ticks(40, c);
    chk("R3 ticks div4", 128'(c), 128'(10));
    wr(8'h04, 32'h0);
    count_ticks(20, c);
    chk("R3 ticks div0", 128'(c), 128'(20));
    wr(8'h04, 32'h4);

    // enables for both flags
    wr(8'h24, 32'h0000_0300);

    // R4 accepted write
    launch(32'h2000_0001, 1'b1, 2'd1, "R4 write");
    rd(8'h08, 32'h2100_0001, "R4 control in flight");

    // R10 writes ignored while in flight
    wr(8'h04, 32'h9);
    rd(8'h04, 32'h4, "R10 divider hold");
    wr(8'h00, 32'h5555);
    rd(8'h00, 32'h1230, "R10 address hold");
    wr(8'h34, 32'h0);
    rd(8'h34, 32'hA000_0001, "R10 data hold");

    // R8 start while in flight
    launch(32'h2000_AA02, 1'b0, 2'd0, "R8 while pending");
    rd(8'h24, 32'h0000_0302, "R8 fail flag");
    rd(8'h08, 32'h2100_0001, "R8 control unchanged");
    @(negedge clk);
    chk("R12 irq on fail", 128'(irq), 128'(1));

    // R9 completion
    finish_op();
    rd(8'h08, 32'h2000_0000, "R9 control after done");
    rd(8'h24, 32'h0000_0303, "R9 done flag");

    // R11 writing 1 keeps, writing 0 clears
    wr(8'h24, 32'h0000_0303);
    rd(8'h24, 32'h0000_0303, "R11 write one keeps");
    wr(8'h24, 32'h0000_0300);
    rd(8'h24, 32'h0000_0300, "R11 write zero clears");
    @(negedge clk);
    chk("R12 irq clear", 128'(irq), 128'(0));

    // R5 page erase accepted, full erase with wrong key rejected
    launch(32'h2000_5504, 1'b1, 2'd2, "R5 page");
    finish_op();
    wr(8'h24, 32'h0000_0300);
    launch(32'h2000_5502, 1'b0, 2'd0, "R5 wrong key");
    rd(8'h24, 32'h0000_0302, "R5 fail flag");
    wr(8'h24, 32'h0000_0300);

    // R6 locked
    launch(32'h3000_AA02, 1'b0, 2'd0, "R6 locked");
    rd(8'h24, 32'h0000_0302, "R6 fail flag");
    rd(8'h08, 32'h3000_AA00, "R6 fields stored");
    wr(8'h24, 32'h0000_0300);

    // R7 two start bits
    launch(32'h2000_5505, 1'b0, 2'd0, "R7 two bits");
    rd(8'h24, 32'h0000_0302, "R7 fail flag");
    wr(8'h24, 32'h0000_0300);

    // R8 macro busy
    fop_busy = 1'b1;
    launch(32'h2000_0001, 1'b0, 2'd0, "R8 busy");
    fop_busy = 1'b0;
    rd(8'h24, 32'h0000_0302, "R8 busy fail flag");
    wr(8'h24, 32'h0000_0300);

    // R4 full erase, then R11 set beats a same-cycle clear
    launch(32'h2000_AA02, 1'b1, 2'd3, "R4 full erase");
    @(posedge clk); #1;
    fop_done = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h24; bus_wdata = 32'h0000_0300;
    @(posedge clk); #1;
    fop_done = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    rd(8'h24, 32'h0000_0301, "R11 set beats clear");

    // R12 only fail enabled: done flag alone leaves irq low
    wr(8'h24, 32'h0000_0201);
    @(negedge clk);
    chk("R12 masked done", 128'(irq), 128'(0));
    wr(8'h24, 32'h0000_0101);
    @(negedge clk);
    chk("R12 enabled done", 128'(irq), 128'(1));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule